// File: doc/BRIEF.md
# Buck Controller Soft-Start Sequencer

This block sequences the start-up of a synchronous buck regulator. It waits for three conditions: the bias supply is good, the bus supply is good, and the enable input is high. Once all three hold, it raises a 10-bit reference code from zero to full scale. The code moves one step for every fixed number of switching-oscillator ticks. An external converter turns the code into the regulator's reference voltage.

The block raises three milestone flags as the code climbs. The quarter flag releases the error amplifier, so a precharged output is not pulled down early in the start-up. The half flag arms the feedback-undervoltage latch-out. The done flag marks that the code has reached full scale and is holding there.

If enable or either supply-good input is lost, the block clears the code and all the flags. The ramp then starts again from zero once all three conditions are back. The three level inputs are asynchronous and pass through synchronisers. The tick input is a one-cycle pulse that is already synchronous to the block clock.

Top module: `softstart_seq`

## Requirements
- R1: While rst_n is low at a clock edge, every flop clears, so after reset `ramp_code` is 0 and `quarter_done`, `half_done` and `ramp_done` are 0.
- R2: The ramp advances only while the synchronised AND of `en_a`, `bias_ok_a` and `bus_ok_a` is high. Each input passes through two flops, so a change on the pins first affects the ramp at the third rising edge after it.
- R3: While running, `ramp_code` rises by exactly 1 on the edge that samples the TICKS_PER_STEP-th `tick` pulse since the last step. Cycles with `tick` low are not counted.
- R4: `ramp_code` saturates at 1023 and stops counting there. `ramp_done` is high exactly when `ramp_code` is 1023.
- R5: `quarter_done` (the error-amplifier release) is high exactly when `ramp_code` is 256 or more, that is when bit 8 or bit 9 is set. It changes in the same cycle as the code.
- R6: `half_done` (the undervoltage-latch arm) is high exactly when `ramp_code` is 512 or more, that is when bit 9 is set. It is never high while `quarter_done` is low.
- R7: When `en_a` is low, the code, the tick count and all flags clear to 0 on the third rising edge after `en_a` falls, and they stay cleared while `en_a` stays low.
- R8: Losing `bias_ok_a` or `bus_ok_a` clears the sequence in the same way as enable low, with the same latency.
- R9: If a clear and a step fall in the same cycle, the clear wins. The code goes to 0 and no milestone flag is raised, even when that step would have crossed a milestone.
- R10: After a clear, once all three conditions return, the ramp starts again from code 0 with an empty tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_a | input | 1 | Enable level, asynchronous |
| bias_ok_a | input | 1 | Bias-supply power-on-reset good, asynchronous |
| bus_ok_a | input | 1 | Bus-supply undervoltage comparator good, asynchronous |
| tick | input | 1 | One-cycle pulse per switching-oscillator period, synchronous |
| ramp_code | output | CODE_W | Reference ramp code |
| quarter_done | output | 1 | Code at or above one quarter of full scale; releases the error amplifier |
| half_done | output | 1 | Code at or above one half of full scale; arms the feedback-undervoltage latch-out |
| ramp_done | output | 1 | Code at full scale |

## Verification
A clear and a ramp step can fall in the same cycle, and the most delicate case is a step that would also cross the quarter milestone. The bench provokes this case on purpose. It stops the ticks with the code at 255 and the tick count one short of a step. It then drops enable and times a tick pulse so that it arrives on exactly the edge where the synchronised clear takes effect. The result is judged against a bench model built from the requirements: the code must read 0 and `quarter_done` must stay low. Random runs, with occasional supply drops, hit the same collision at other codes.

// File: rtl/softstart_pkg.sv
// Package: shared types for the soft-start sequencer.
// Assumes: nothing; holds only a type definition.
package softstart_pkg;

    // Milestone flags raised as the ramp climbs.
    typedef struct packed {
        logic quarter;
        logic half;
        logic full;
    } ss_flags_t;

endpackage

// File: rtl/ss_sync_bank.sv
// Module: ss_sync_bank
// A bank of multi-flop synchronisers, one chain for each input bit.
// Assumes: the input bits are quasi-static levels. They are not combined
// before synchronising, so each bit has its own chain.
module ss_sync_bank #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw level through STAGES flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_async[b]};
        end

        assign q_sync[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/ss_step_div.sv
// Module: ss_step_div
// Counts oscillator ticks and raises a one-cycle step pulse on every
// TICKS-th tick while the sequence runs.
// Assumes: tick is a synchronous single-cycle pulse. When run is low the
// count is emptied. When hold is high the count freezes and no step is issued.
module ss_step_div #(
    parameter int TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold,
    input  logic tick,
    output logic step
);

    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          advance;

    // Decide whether this cycle's tick counts.
    always_comb begin
        advance = run && tick && !hold;
        step    = advance && (cnt_q == LAST);
    end

    // Tick counter: cleared when not running, wraps when a step is issued.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (advance)   cnt_q <= step ? '0 : cnt_q + CW'(1);
    end

endmodule

// File: rtl/ss_ramp_ctr.sv
// Module: ss_ramp_ctr
// Holds the reference ramp code. The code steps by one on each step pulse
// and is forced to zero whenever run is low. The next-state value is also
// an output, so that the milestone flags can be registered in step with it.
// Assumes: the step pulse is never issued while the code is at full scale.
module ss_ramp_ctr #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              step,
    output logic [CODE_W-1:0] code_q,
    output logic [CODE_W-1:0] code_next,
    output logic              at_max
);

    // Next code: clear dominates, then increment on a step.
    always_comb begin
        if (!run)      code_next = '0;
        else if (step) code_next = code_q + CODE_W'(1);
        else           code_next = code_q;
        at_max = &code_q;
    end

    // Code register.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_next;
    end

endmodule

// File: rtl/ss_milestones.sv
// Module: ss_milestones
// Registers the quarter, half and full-scale flags from the next ramp code,
// so that each flag changes in the same cycle as the code it describes.
// Assumes: code_next is already zero whenever the sequence is cleared.
module ss_milestones
    import softstart_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_next,
    output ss_flags_t         flags_q
);

    ss_flags_t flags_d;

    // Decode the milestone thresholds from the top code bits.
    always_comb begin
        flags_d.quarter = code_next[CODE_W-1] | code_next[CODE_W-2];
        flags_d.half    = code_next[CODE_W-1];
        flags_d.full    = &code_next;
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

endmodule

// File: rtl/softstart_seq.sv
// Module: softstart_seq (top)
// Digital soft-start sequencer. It synchronises the enable and supply-good
// levels and requires all three to be high. While they are, it steps a
// reference ramp code from zero to full scale once every TICKS_PER_STEP
// oscillator ticks and raises the milestone flags.
// Assumes: tick is synchronous to clk. The other inputs may be asynchronous.
module softstart_seq
    import softstart_pkg::*;
#(
    parameter int CODE_W         = 10,
    parameter int TICKS_PER_STEP = 2,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_a,
    input  logic              bias_ok_a,
    input  logic              bus_ok_a,
    input  logic              tick,
    output logic [CODE_W-1:0] ramp_code,
    output logic              quarter_done,
    output logic              half_done,
    output logic              ramp_done
);

    localparam int NCOND = 3;

    logic [NCOND-1:0]  cond_sync;
    logic              run;
    logic              step;
    logic              at_max;
    logic [CODE_W-1:0] code_next;
    ss_flags_t         flags;

    ss_sync_bank #(.WIDTH(NCOND), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({en_a, bias_ok_a, bus_ok_a}),
        .q_sync  (cond_sync)
    );

    // The sequence runs only while every start condition is good.
    always_comb run = &cond_sync;

    ss_step_div #(.TICKS(TICKS_PER_STEP)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .hold  (at_max),
        .tick  (tick),
        .step  (step)
    );

    ss_ramp_ctr #(.CODE_W(CODE_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .step      (step),
        .code_q    (ramp_code),
        .code_next (code_next),
        .at_max    (at_max)
    );

    ss_milestones #(.CODE_W(CODE_W)) u_miles (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_next (code_next),
        .flags_q   (flags)
    );

    // Route the registered flags to the outputs.
    always_comb begin
        quarter_done = flags.quarter;
        half_done    = flags.half;
        ramp_done    = flags.full;
    end

endmodule

// File: rtl/ss_seq_chk.sv
// Module: ss_seq_chk
// Temporal checks on the sequencer ports, bound into every softstart_seq.
module ss_seq_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_a,
    input logic [CODE_W-1:0] ramp_code,
    input logic              quarter_done,
    input logic              half_done,
    input logic              ramp_done
);

    localparam logic [CODE_W-1:0] QTR  = CODE_W'(1) << (CODE_W - 2);
    localparam logic [CODE_W-1:0] HALF = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] FULL = '1;

    // R3
    code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_code != $past(ramp_code)) |->
        ((ramp_code == $past(ramp_code) + CODE_W'(1)) || (ramp_code == '0)));

    // R4
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done |=> ((ramp_code == FULL) || (ramp_code == '0)));

    // R5
    quarter_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quarter_done == (ramp_code >= QTR));

    // R6
    half_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_done == (ramp_code >= HALF));

    // R6
    half_after_quarter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_done |-> quarter_done);

    // R7
    enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_a && !$past(en_a) && !$past(en_a, 2)) |=>
        ((ramp_code == '0) && !quarter_done && !half_done && !ramp_done));

endmodule

bind softstart_seq ss_seq_chk #(.CODE_W(CODE_W)) u_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_a         (en_a),
    .ramp_code    (ramp_code),
    .quarter_done (quarter_done),
    .half_done    (half_done),
    .ramp_done    (ramp_done)
);

// File: tb/test_softstart_seq.sv
module test_softstart_seq;

    localparam int W     = 10;
    localparam int T     = 3;
    localparam int MAXC  = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_a = 1'b0, bias_ok_a = 1'b0, bus_ok_a = 1'b0, tick = 1'b0;
    logic [W-1:0] ramp_code;
    logic quarter_done, half_done, ramp_done;

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";

    // Reference model state, built from the requirements.
    int m_code = 0, m_cnt = 0;
    bit m_s1 = 1'b0, m_s2 = 1'b0;

    always #5 clk = ~clk;

    softstart_seq #(.CODE_W(W), .TICKS_PER_STEP(T), .SYNC_STAGES(2)) i_softstart_seq (
        .clk(clk), .rst_n(rst_n), .en_a(en_a), .bias_ok_a(bias_ok_a),
        .bus_ok_a(bus_ok_a), .tick(tick), .ramp_code(ramp_code),
        .quarter_done(quarter_done), .half_done(half_done), .ramp_done(ramp_done)
    );

    function automatic bit exp_quarter(int c); return c >= (1 << (W - 2)); endfunction
    function automatic bit exp_half(int c);    return c >= (1 << (W - 1)); endfunction
    function automatic bit exp_full(int c);    return c == MAXC;           endfunction

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check(cur_req, "ramp_code", int'(ramp_code), m_code);
        check("R5", "quarter_done", int'(quarter_done), int'(exp_quarter(m_code)));
        check("R6", "half_done", int'(half_done), int'(exp_half(m_code)));
        check("R4", "ramp_done", int'(ramp_done), int'(exp_full(m_code)));
    endtask

    // Advance the model by one rising edge, using the inputs just driven.
    task automatic model_edge();
        if (!rst_n) begin
            m_code = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            if (!m_s2) begin
                m_code = 0; m_cnt = 0;
            end else if (tick && m_code != MAXC) begin
                if (m_cnt == T - 1) begin m_cnt = 0; m_code++; end
                else m_cnt++;
            end
            m_s2 = m_s1;
            m_s1 = en_a & bias_ok_a & bus_ok_a;
        end
    endtask

    // One cycle: check at the falling edge, drive new inputs, advance the model.
    task automatic cyc(bit en, bit bias, bit bus, bit tk);
        @(negedge clk);
        check_all();
        en_a = en; bias_ok_a = bias; bus_ok_a = bus; tick = tk;
        model_edge();
    endtask

    initial begin : watchdog
        #(200000 * 10);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5eed_1234));
        // R1: reset state.
        rst_n = 1'b0;
        repeat (4) begin @(negedge clk); model_edge(); end
        @(negedge clk);
        check_all();
        rst_n = 1'b1;
        model_edge();

        // R2: the ramp is held off unless every condition is good.
        cur_req = "R2";
        repeat (20) cyc(1'b0, 1'b1, 1'b1, 1'b1);
        repeat (20) cyc(1'b1, 1'b0, 1'b1, 1'b1);
        repeat (20) cyc(1'b1, 1'b1, 1'b0, 1'b1);

        // R3 R4 R5 R6: full ramp with steady ticks, then saturation.
        cur_req = "R3";
        while (m_code != MAXC) cyc(1'b1, 1'b1, 1'b1, 1'b1);
        cur_req = "R4";
        repeat (40) cyc(1'b1, 1'b1, 1'b1, 1'b1);

        // R8: loss of the bus supply clears; R10: restart from zero.
        cur_req = "R8";
        repeat (6) cyc(1'b1, 1'b1, 1'b0, 1'b1);
        cur_req = "R10";
        repeat (40) cyc(1'b1, 1'b1, 1'b1, (($urandom % 2) == 0));
        cur_req = "R8";
        repeat (6) cyc(1'b1, 1'b0, 1'b1, 1'b1);

        // R9: clear lands on the edge where a step would cross the quarter mark.
        cur_req = "R9";
        while (!(m_code == (1 << (W - 2)) - 1 && m_cnt == T - 1))
            cyc(1'b1, 1'b1, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 1'b1);
        // R7: enable held low keeps everything cleared.
        cur_req = "R7";
        repeat (10) cyc(1'b0, 1'b1, 1'b1, 1'b1);

        // Random phase: irregular ticks, rare drops of each condition.
        cur_req = "R3";
        for (int i = 0; i < 30000; i++) begin
            bit en = (($urandom % 1500) != 0);
            bit bi = (($urandom % 3000) != 0);
            bit bu = (($urandom % 3000) != 0);
            cyc(en, bi, bu, (($urandom % 10) < 7));
        end

        @(negedge clk);
        check_all();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule